// File: doc/BRIEF.md
# Phase-Offset Pulse Generator with Committed Update

A single-channel pulse generator that runs on its own PWM clock. Software programs a period, a pulse width and a phase offset, each a count of clock cycles. Within every period the output is active for a run of cycles that starts at the programmed offset. These values go into staged copies first. They reach the waveform only when software sets a commit bit, and then only at the next period boundary, so the three values always change together.

The channel runs only while both its output-enable and clock-enable bits are set. Clearing either bit stops it at once and the pin keeps its last level. In continuous mode the waveform repeats without end. In one-shot mode the block runs a programmed number of periods, drives the pin inactive, clears its own output enable and pulses a completion interrupt. A registered read port returns the staged values, the enables, the control word and whether a commit is still pending.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset, pwm_out and done_irq are 0 and every register at addresses 0 to 4 reads back as 0.
- R2: While running, the counter steps from 0 to P-1 and then wraps. pwm_out is 1 exactly when offset <= count < offset+duty. pwm_out lags the counter by one cycle, and counting starts at 0 on the first clock edge after the run condition becomes true.
- R3: On load, duty is limited to period and offset is limited to period minus the limited duty. A period of 0 or a duty of 0 gives a constantly inactive output.
- R4: Writes to period (address 1), duty (address 2) and offset (address 3) do not change the waveform until a commit.
- R5: A commit made while running takes effect at the first period boundary after it, and the new period starts at count 0. A commit made while stopped loads on the next clock edge.
- R6: Bit 2 of address 0 reads back as 1 from the commit until the load, then as 0. The commit is requested by writing a 1 to that bit with its mask bit set.
- R7: Writes to address 0 (enable) and address 4 (control) are masked. Bits 31:16 enable the update of bits 15:0 one for one, and bits that are not enabled keep their value.
- R8: Address 0 bit 0 is output enable and bit 1 is clock enable. The channel runs only when both are 1. Clearing either stops counting at once, and pwm_out holds its last level.
- R9: Address 4 bit 0 selects one-shot mode (1) or continuous mode (0), and bits 15:8 hold the repeat count N, where 0 means 1. In one-shot mode the block stops at the end of period N: at that boundary pwm_out is forced to 0, the output enable bit clears and done_irq is high for exactly one cycle.
- R10: In continuous mode done_irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_addr |
| pwm_out | output | 1 | Registered pulse output |
| done_irq | output | 1 | One-cycle pulse when a one-shot run completes |

## Verification
On every cycle the assertions check four things: the loaded offset plus duty never exceeds the loaded period, a stopped channel keeps its pin level, a pending commit clears once the channel is stopped, and the completion pulse lasts one cycle and appears only in one-shot mode. The bench sweeps every period from 0 to 5 against duty and offset values both inside and past the legal range, and compares each output sample with an arithmetic model of the window. Only the scenarios can show when a commit lands in relation to the period boundary, that uncommitted writes are ignored, that masked writes keep their other bits, and where a one-shot run ends.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int BUS_W   = 32;
  localparam int HALF_W  = 16;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ENA  = 3'd0,
    A_PER  = 3'd1,
    A_DUTY = 3'd2,
    A_OFS  = 3'd3,
    A_CTRL = 3'd4
  } reg_addr_e;

  // bit positions inside the enable and control images
  localparam int B_OUT    = 0;
  localparam int B_CLK    = 1;
  localparam int B_COMMIT = 2;
  localparam int B_MODE   = 0;
  localparam int RPT_LSB  = 8;

  typedef enum logic {
    M_CONT    = 1'b0,
    M_ONESHOT = 1'b1
  } run_mode_e;

  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_v,
    input logic [BUS_W-1:0]  wd
  );
    return (old_v & ~wd[BUS_W-1:HALF_W]) | (wd[HALF_W-1:0] & wd[BUS_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RPT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              load_done,
  input  logic              os_done,
  output logic              out_en,
  output logic              clk_en,
  output logic              pend,
  output logic              cm_set,
  output run_mode_e         mode,
  output logic [RPT_W-1:0]  rpt,
  output logic [CNT_W-1:0]  sh_per,
  output logic [CNT_W-1:0]  sh_duty,
  output logic [CNT_W-1:0]  sh_ofs,
  output logic [BUS_W-1:0]  rd_data
);
  logic [HALF_W-1:0] ena_img, ena_new, ctl_img, ctl_new;
  logic              ena_wr, ctl_wr;
  logic [BUS_W-1:0]  rd_mux;

  assign ena_img = HALF_W'({clk_en, out_en});
  assign ctl_img = HALF_W'({rpt, {(RPT_LSB-1){1'b0}}, mode == M_ONESHOT});
  assign ena_new = masked_merge(ena_img, wr_data);
  assign ctl_new = masked_merge(ctl_img, wr_data);
  assign ena_wr  = wr_en && (wr_addr == A_ENA);
  assign ctl_wr  = wr_en && (wr_addr == A_CTRL);
  assign cm_set  = ena_wr && wr_data[B_COMMIT] && wr_data[HALF_W+B_COMMIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en  <= 1'b0;
      clk_en  <= 1'b0;
      pend    <= 1'b0;
      mode    <= M_CONT;
      rpt     <= '0;
      sh_per  <= '0;
      sh_duty <= '0;
      sh_ofs  <= '0;
    end else begin
      if (os_done)   out_en <= 1'b0;
      if (load_done) pend   <= 1'b0;
      if (cm_set)    pend   <= 1'b1;
      if (ena_wr) begin
        out_en <= ena_new[B_OUT];
        clk_en <= ena_new[B_CLK];
      end
      if (ctl_wr) begin
        mode <= ctl_new[B_MODE] ? M_ONESHOT : M_CONT;
        rpt  <= ctl_new[RPT_LSB +: RPT_W];
      end
      if (wr_en && wr_addr == A_PER)  sh_per  <= wr_data[CNT_W-1:0];
      if (wr_en && wr_addr == A_DUTY) sh_duty <= wr_data[CNT_W-1:0];
      if (wr_en && wr_addr == A_OFS)  sh_ofs  <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_ENA:   rd_mux = BUS_W'({pend, clk_en, out_en});
      A_PER:   rd_mux = BUS_W'(sh_per);
      A_DUTY:  rd_mux = BUS_W'(sh_duty);
      A_OFS:   rd_mux = BUS_W'(sh_ofs);
      A_CTRL:  rd_mux = BUS_W'(ctl_img);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pwm_legalize.sv
module pwm_legalize #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] ofs_in,
  output logic [CNT_W-1:0] duty_out,
  output logic [CNT_W-1:0] ofs_out
);
  logic [CNT_W-1:0] room;

  always_comb begin
    duty_out = (duty_in > per_in) ? per_in : duty_in;
    room     = per_in - duty_out;
    ofs_out  = (ofs_in > room) ? room : ofs_in;
  end
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine #(
  parameter int CNT_W = 32,
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             oneshot,
  input  logic [RPT_W-1:0] rpt,
  input  logic             load,
  input  logic [CNT_W-1:0] new_per,
  input  logic [CNT_W-1:0] new_duty,
  input  logic [CNT_W-1:0] new_ofs,
  output logic             boundary,
  output logic             os_done,
  output logic [CNT_W-1:0] act_per,
  output logic [CNT_W-1:0] act_duty,
  output logic [CNT_W-1:0] act_ofs,
  output logic             pwm_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt;
  logic [RPT_W-1:0] rep, rpt_m1;
  logic [CNT_W:0]   win_end;
  logic             in_win;

  assign boundary = (act_per == '0) || (cnt == act_per - 1'b1);
  assign win_end  = {1'b0, act_ofs} + {1'b0, act_duty};
  assign in_win   = (cnt >= act_ofs) && ({1'b0, cnt} < win_end);
  assign rpt_m1   = (rpt == '0) ? '0 : rpt - 1'b1;
  assign os_done  = run && oneshot && boundary && (rep == rpt_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rep      <= '0;
      act_per  <= '0;
      act_duty <= '0;
      act_ofs  <= '0;
      pwm_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= os_done;
      if (load) begin
        act_per  <= new_per;
        act_duty <= new_duty;
        act_ofs  <= new_ofs;
      end
      if (!run) begin
        cnt <= '0;
        rep <= '0;
      end else begin
        pwm_q <= os_done ? 1'b0 : in_win;
        if (boundary) begin
          cnt <= '0;
          if (oneshot) rep <= rep + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RPT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        pwm_out,
  output logic        done_irq
);
  logic             out_en, clk_en, pend, cm_set, run, load, boundary, os_done;
  run_mode_e        mode;
  logic [RPT_W-1:0] rpt;
  logic [CNT_W-1:0] sh_per, sh_duty, sh_ofs, lg_duty, lg_ofs;
  logic [CNT_W-1:0] act_per, act_duty, act_ofs;

  assign run  = out_en && clk_en;
  assign load = pend && (!run || boundary);

  pwm_regs #(.CNT_W(CNT_W), .RPT_W(RPT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .load_done(load), .os_done(os_done),
    .out_en(out_en), .clk_en(clk_en), .pend(pend), .cm_set(cm_set),
    .mode(mode), .rpt(rpt), .sh_per(sh_per), .sh_duty(sh_duty),
    .sh_ofs(sh_ofs), .rd_data(rd_data)
  );

  pwm_legalize #(.CNT_W(CNT_W)) u_legal (
    .per_in(sh_per), .duty_in(sh_duty), .ofs_in(sh_ofs),
    .duty_out(lg_duty), .ofs_out(lg_ofs)
  );

  pwm_engine #(.CNT_W(CNT_W), .RPT_W(RPT_W)) u_eng (
    .clk(clk), .rst(rst), .run(run), .oneshot(mode == M_ONESHOT), .rpt(rpt),
    .load(load), .new_per(sh_per), .new_duty(lg_duty), .new_ofs(lg_ofs),
    .boundary(boundary), .os_done(os_done), .act_per(act_per),
    .act_duty(act_duty), .act_ofs(act_ofs), .pwm_q(pwm_out), .irq_q(done_irq)
  );
endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             pend,
  input logic             cm_set,
  input logic             oneshot,
  input logic             pwm_out,
  input logic             done_irq,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_duty,
  input logic [CNT_W-1:0] act_ofs
);
  // R3: the loaded window always fits inside the loaded period
  a_r3_window_fits: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, act_ofs} + {1'b0, act_duty}) <= {1'b0, act_per});

  // R3: zero period drives the output inactive
  a_r3_zero_period: assert property (@(posedge clk) disable iff (rst)
    (run && act_per == '0) |=> !pwm_out);

  // R8: a stopped channel keeps its pin level
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pwm_out));

  // R5 / R6: pending commit is consumed at once while stopped
  a_r6_pend_clears: assert property (@(posedge clk) disable iff (rst)
    (pend && !run && !cm_set) |=> !pend);

  // R9: completion pulse is one cycle wide
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R10: completion pulse only follows one-shot operation
  a_r10_irq_oneshot: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $past(oneshot));
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .pend(pend), .cm_set(cm_set),
  .oneshot(mode == pwm_phase_pkg::M_ONESHOT), .pwm_out(pwm_out),
  .done_irq(done_irq), .act_per(act_per), .act_duty(act_duty),
  .act_ofs(act_ofs)
);

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb;
  localparam real TCK = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pwm_out, done_irq;

  int total = 0;
  int bad = 0;

  always #(TCK/2) clk = ~clk;

  pwm_phase_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .done_irq(done_irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit fexp(input int p, input int d, input int o, input int k);
    return (p != 0) && (k >= o) && (k < o + d);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic stop_ch();   wr(3'd0, 32'h0003_0000); endtask
  task automatic start_ch();  wr(3'd0, 32'h0003_0003); endtask
  task automatic commit_ch(); wr(3'd0, 32'h0004_0004); endtask

  task automatic load_cfg(input int p, input int d, input int o);
    stop_ch();
    wr(3'd1, p); wr(3'd2, d); wr(3'd3, o);
    commit_ch();
    tick();
  endtask

  initial begin
    #(TCK * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    check(pwm_out === 1'b0 && done_irq === 1'b0, "R1 outputs", pwm_out, 0);
    for (int a = 0; a < 5; a++) begin
      rd_addr = a[2:0];
      tick();
      check(rd_data === 32'd0, "R1 readback", rd_data, 0);
    end
    rd_addr = 3'd0;

    // R2 / R3 / R10 sweep in continuous mode
    wr(3'd4, 32'hFFFF_0000);
    for (int p = 0; p <= 5; p++) begin
      for (int d = 0; d <= 6; d++) begin
        for (int o = 0; o <= 6; o++) begin
          int dc, oc, n, k;
          bit ok;
          int first_bad;
          dc = (d > p) ? p : d;
          oc = (o > p - dc) ? p - dc : o;
          load_cfg(p, d, o);
          start_ch();
          ok = 1'b1; first_bad = -1;
          n = 2 * ((p == 0) ? 2 : p);
          for (int i = 1; i <= n; i++) begin
            tick();
            k = (p == 0) ? 0 : (i - 1) % p;
            if (pwm_out !== fexp(p, dc, oc, k) || done_irq !== 1'b0) begin
              if (ok) first_bad = i;
              ok = 1'b0;
            end
          end
          check(ok, (d > p || o > p - dc) ? "R3 clamp window" : "R2 R10 window",
                first_bad, -1);
        end
      end
    end

    // R4 R5 R6: commit while running
    begin
      bit ok_old, ok_new;
      load_cfg(5, 2, 1);
      rd_addr = 3'd0;
      start_ch();
      ok_old = 1'b1; ok_new = 1'b1;
      for (int i = 1; i <= 30; i++) begin
        tick();
        if (i <= 15) begin
          if (pwm_out !== fexp(5, 2, 1, (i - 1) % 5)) ok_old = 1'b0;
        end else begin
          if (pwm_out !== fexp(3, 1, 2, (i - 16) % 3)) ok_new = 1'b0;
        end
        if (i == 11) check(rd_data[2] === 1'b1, "R6 pending set", rd_data[2], 1);
        if (i == 16) check(rd_data[2] === 1'b0, "R6 pending cleared", rd_data[2], 0);
        wr_en = 1'b0;
        case (i)
          6: begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd3; end
          7: begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'd1; end
          8: begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'd2; end
          9: begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0004_0004; end
          default: ;
        endcase
      end
      check(ok_old, "R4 staged writes ignored", ok_old, 1);
      check(ok_new, "R5 commit at boundary", ok_new, 1);
    end

    // R8 / R7: abrupt stop holds the level, masked enable write
    begin
      bit ok;
      load_cfg(6, 4, 1);
      start_ch();
      tick(); tick();
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0002_0000;
      tick();
      wr_en = 1'b0;
      check(pwm_out === 1'b1, "R2 level before stop", pwm_out, 1);
      ok = 1'b1;
      for (int i = 5; i <= 12; i++) begin
        tick();
        if (pwm_out !== 1'b1) ok = 1'b0;
      end
      check(ok, "R8 hold after clock enable cleared", pwm_out, 1);
      check(rd_data === 32'd1, "R7 out enable kept", rd_data, 1);
      wr(3'd0, 32'h0003_0002);
      repeat (4) tick();
      check(rd_data === 32'd2 && pwm_out === 1'b1, "R8 out enable cleared stays stopped",
            rd_data, 2);
    end

    // R9 one-shot, three periods
    begin
      bit ok_w, ok_i;
      load_cfg(4, 2, 1);
      wr(3'd4, 32'hFFFF_0301);
      start_ch();
      ok_w = 1'b1; ok_i = 1'b1;
      for (int i = 1; i <= 20; i++) begin
        tick();
        if (pwm_out !== ((i <= 11) ? fexp(4, 2, 1, (i - 1) % 4) : 1'b0)) ok_w = 1'b0;
        if (done_irq !== (i == 12)) ok_i = 1'b0;
      end
      check(ok_w, "R9 one-shot waveform", ok_w, 1);
      check(ok_i, "R9 single completion pulse", ok_i, 1);
      check(rd_data === 32'd2, "R9 out enable self-cleared", rd_data, 2);
      // R7 masked control write keeps repeat count
      wr(3'd4, 32'h0001_0000);
      rd_addr = 3'd4;
      tick();
      check(rd_data === 32'h0000_0300, "R7 control mask", rd_data, 32'h300);
      rd_addr = 3'd0;
      // R9 repeat count 0 acts as 1
      wr(3'd4, 32'hFFFF_0001);
      start_ch();
      ok_i = 1'b1;
      for (int i = 1; i <= 10; i++) begin
        tick();
        if (done_irq !== (i == 4)) ok_i = 1'b0;
      end
      check(ok_i, "R9 repeat zero means one", ok_i, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule